// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the ALU of a five-stage in-order pipeline. For each of the two source operands of the instruction in the execute stage, it decides whether the register-file copy is stale. If it is stale, the block picks the newer result that an older instruction still carries down the pipeline. One candidate is the ALU result held in the execute/memory boundary register. The other is the write-back value of the memory/write-back boundary register, taken after the load-or-ALU result choice.

The decision is purely combinational. Each operand has a comparator per producing stage, a priority picker that yields a 2-bit select code, and an operand multiplexer driven by that code. The multiplexers are included so that the chosen operand can be observed directly. The block keeps no state, so it has no reset and no state machine. Stalls for load-use hazards are handled elsewhere.

Top module: `fwdu_top`

## Requirements
- R1: When neither producing stage matches an operand, that operand's select code is 00 and the operand equals its register-file value.
- R2: When the execute/memory stage is writing, its destination is nonzero and it equals an operand's source register, that operand's select code is 10 and the operand equals the execute/memory value.
- R3: When the memory/write-back stage is writing, its destination is nonzero and it equals an operand's source register, and the execute/memory stage does not also match that operand, the select code is 01 and the operand equals the memory/write-back value.
- R4: When both producing stages match the same operand, the execute/memory stage wins: the code is 10.
- R5: A destination of register 0 never causes forwarding from either stage, even when the write enable is set and the source is 0.
- R6: A stage whose write enable is low never causes forwarding, whatever its destination.
- R7: The two operands are decided independently. If both sources name the same producer's destination, both codes select that producer.
- R8: The select code 11 is never produced. If the operand multiplexer ever sees it, the multiplexer passes the register-file value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | REG_AW | First source register of the execute-stage instruction |
| ex_src_b | input | REG_AW | Second source register of the execute-stage instruction |
| mem_wen | input | 1 | Execute/memory stage will write a register |
| mem_dst | input | REG_AW | Destination register held at execute/memory |
| wb_wen | input | 1 | Memory/write-back stage will write a register |
| wb_dst | input | REG_AW | Destination register held at memory/write-back |
| rf_val_a | input | DATA_W | Register-file value for the first operand |
| rf_val_b | input | DATA_W | Register-file value for the second operand |
| mem_val | input | DATA_W | ALU result held at execute/memory |
| wb_val | input | DATA_W | Write-back value at memory/write-back |
| sel_a | output | 2 | Select code for the first operand (00 file, 10 exec/mem, 01 mem/wb) |
| sel_b | output | 2 | Select code for the second operand |
| opnd_a | output | DATA_W | First ALU operand after selection |
| opnd_b | output | DATA_W | Second ALU operand after selection |

## Verification
The hardest case to reach is the one where both stages are writing the same nonzero register that an operand reads. Only the priority rule separates a correct result from a stale one there, and register 0 has to be shown inert in the same corner. The bench shrinks the register index to three bits. It then sweeps every combination of both sources, both destinations and both write enables, so every double match, every register-0 match and every shared-producer case occurs. Expected codes and operands come from an arithmetic model in the bench.

// File: rtl/fwdu_pkg.sv
package fwdu_pkg;

    // Select encoding seen by the operand multiplexers.
    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_WB    = 2'b01,
        SEL_MEM   = 2'b10,
        SEL_UNUSED = 2'b11
    } fwd_sel_e;

    localparam int NUM_OPND = 2;

endpackage

// File: rtl/fwdu_hit.sv
module fwdu_hit #(
    parameter int REG_AW = 5
) (
    input  logic              wen,
    input  logic [REG_AW-1:0] dst,
    input  logic [REG_AW-1:0] src,
    output logic              hit
);

    logic dst_live;

    // Register 0 is hardwired; a write to it carries nothing worth forwarding.
    always_comb begin
        dst_live = (dst != '0);
        hit      = wen && dst_live && (dst == src);
    end

endmodule

// File: rtl/fwdu_pick.sv
module fwdu_pick
    import fwdu_pkg::*;
(
    input  logic     mem_hit,
    input  logic     wb_hit,
    output fwd_sel_e sel
);

    // The younger producer (execute/memory) wins over memory/write-back.
    always_comb begin
        unique case ({mem_hit, wb_hit})
            2'b00:   sel = SEL_RF;
            2'b01:   sel = SEL_WB;
            2'b10:   sel = SEL_MEM;
            2'b11:   sel = SEL_MEM;
            default: sel = SEL_RF;
        endcase
    end

    always_comb begin
        if (wb_hit && !mem_hit) begin
            assert_wb_only_R3: assert (sel == SEL_WB);
        end
        assert_no_code11_R8: assert (sel != SEL_UNUSED);
    end

endmodule

// File: rtl/fwdu_opmux.sv
module fwdu_opmux
    import fwdu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd
);

    always_comb begin
        unique case (sel)
            SEL_MEM: opnd = mem_val;
            SEL_WB:  opnd = wb_val;
            default: opnd = rf_val;   // SEL_RF and the unused code
        endcase
    end

    always_comb begin
        if (sel == SEL_RF) begin
            assert_rf_pass_R1: assert (opnd == rf_val);
        end
    end

endmodule

// File: rtl/fwdu_top.sv
module fwdu_top
    import fwdu_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              wb_wen,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic [DATA_W-1:0] rf_val_a,
    input  logic [DATA_W-1:0] rf_val_b,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    logic [NUM_OPND-1:0][REG_AW-1:0] src_v;
    logic [NUM_OPND-1:0][DATA_W-1:0] rf_v;
    logic [NUM_OPND-1:0][DATA_W-1:0] opnd_v;
    fwd_sel_e                        sel_v [NUM_OPND];

    assign src_v[0] = ex_src_a;
    assign src_v[1] = ex_src_b;
    assign rf_v[0]  = rf_val_a;
    assign rf_v[1]  = rf_val_b;

    // One identical decision slice per ALU operand.
    generate
        for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
            logic mem_hit;
            logic wb_hit;

            fwdu_hit #(.REG_AW(REG_AW)) u_mem_hit (
                .wen (mem_wen),
                .dst (mem_dst),
                .src (src_v[g]),
                .hit (mem_hit)
            );

            fwdu_hit #(.REG_AW(REG_AW)) u_wb_hit (
                .wen (wb_wen),
                .dst (wb_dst),
                .src (src_v[g]),
                .hit (wb_hit)
            );

            fwdu_pick u_pick (
                .mem_hit (mem_hit),
                .wb_hit  (wb_hit),
                .sel     (sel_v[g])
            );

            fwdu_opmux #(.DATA_W(DATA_W)) u_mux (
                .sel     (sel_v[g]),
                .rf_val  (rf_v[g]),
                .mem_val (mem_val),
                .wb_val  (wb_val),
                .opnd    (opnd_v[g])
            );
        end
    endgenerate

    assign sel_a  = sel_v[0];
    assign sel_b  = sel_v[1];
    assign opnd_a = opnd_v[0];
    assign opnd_b = opnd_v[1];

    // Port-level checks against the input conditions.
    always_comb begin
        if (mem_wen && (mem_dst != '0) && (mem_dst == ex_src_a)) begin
            assert_mem_first_a_R2: assert (sel_a == 2'b10 && opnd_a == mem_val);
        end
        if (mem_wen && (mem_dst != '0) && (mem_dst == ex_src_b)) begin
            assert_mem_first_b_R4: assert (sel_b == 2'b10 && opnd_b == mem_val);
        end
        if (!mem_wen && !wb_wen) begin
            assert_idle_stages_R6: assert (sel_a == 2'b00 && sel_b == 2'b00);
        end
        if (ex_src_a == '0) begin
            assert_zero_reg_R5: assert (sel_a == 2'b00 && opnd_a == rf_val_a);
        end
        if (ex_src_a == ex_src_b) begin
            assert_same_src_R7: assert (sel_a == sel_b);
        end
    end

endmodule

// File: tb/tb_fwdu_top.sv
module tb_fwdu_top;

    localparam int AW = 3;
    localparam int DW = 32;
    localparam int NREG = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic [AW-1:0] src_a, src_b, mdst, wdst;
    logic          mwen, wwen;
    logic [DW-1:0] rfa, rfb, mval, wval;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    fwdu_top #(.REG_AW(AW), .DATA_W(DW)) dut (
        .ex_src_a (src_a), .ex_src_b (src_b),
        .mem_wen  (mwen),  .mem_dst  (mdst),
        .wb_wen   (wwen),  .wb_dst   (wdst),
        .rf_val_a (rfa),   .rf_val_b (rfb),
        .mem_val  (mval),  .wb_val   (wval),
        .sel_a    (sel_a), .sel_b    (sel_b),
        .opnd_a   (opnd_a), .opnd_b  (opnd_b)
    );

    function automatic logic [1:0] model_sel(input logic [AW-1:0] s);
        bit mh = mwen && (mdst != 0) && (mdst == s);
        bit wh = wwen && (wdst != 0) && (wdst == s);
        if (mh) return 2'b10;        // R2, R4
        if (wh) return 2'b01;        // R3
        return 2'b00;                // R1, R5, R6
    endfunction

    function automatic string req_of(input logic [AW-1:0] s);
        bit mh = mwen && (mdst == s);
        bit wh = wwen && (wdst == s);
        if (s == 0 && (mh || wh)) return "R5";
        if (mh && wh) return "R4";
        if (mwen && mdst == s) return "R2";
        if (wwen && wdst == s) return "R3";
        if ((mdst == s) || (wdst == s)) return "R6";
        return "R1";
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (a=%0d b=%0d mw=%0b md=%0d ww=%0b wd=%0d)",
                     req, act, exp, src_a, src_b, mwen, mdst, wwen, wdst);
        end
    endtask

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
        case (s)
            2'b10:   return mval;
            2'b01:   return wval;
            default: return rf;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [1:0] ea, eb;
        src_a = 0; src_b = 0; mdst = 0; wdst = 0; mwen = 0; wwen = 0;
        mval = 32'hBEEF_0001; wval = 32'hCAFE_0002;
        rfa = 32'h1111_0000; rfb = 32'h2222_0000;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Initial quiet state: R1
        chk("R1", {30'd0, sel_a}, 32'd0);
        chk("R1", {30'd0, sel_b}, 32'd0);
        chk("R1", opnd_a, rfa);

        for (int v = 0; v < (NREG*NREG*NREG*NREG*4); v++) begin
            @(posedge clk);
            src_a = AW'(v);
            src_b = AW'(v >> AW);
            mdst  = AW'(v >> (2*AW));
            wdst  = AW'(v >> (3*AW));
            mwen  = v[4*AW];
            wwen  = v[4*AW+1];
            rfa   = 32'h1000_0000 + v;
            rfb   = 32'h2000_0000 + v;
            mval  = 32'h3000_0000 + v;
            wval  = 32'h4000_0000 + v;
            @(negedge clk);
            ea = model_sel(src_a);
            eb = model_sel(src_b);
            chk(req_of(src_a), {30'd0, sel_a}, {30'd0, ea});
            chk(req_of(src_b), {30'd0, sel_b}, {30'd0, eb});
            chk(req_of(src_a), opnd_a, pick(ea, rfa));
            chk(req_of(src_b), opnd_b, pick(eb, rfb));
            if (src_a == src_b) chk("R7", {30'd0, sel_a}, {30'd0, sel_b});
            if (sel_a == 2'b11 || sel_b == 2'b11) chk("R8", {30'd0, sel_a}, 32'd0);
        end

        // Directed: both operands read the exec/mem destination, R7
        @(posedge clk);
        src_a = 3'd5; src_b = 3'd5; mwen = 1; mdst = 3'd5; wwen = 1; wdst = 3'd5;
        @(negedge clk);
        chk("R7", {30'd0, sel_a}, 32'd2);
        chk("R7", {30'd0, sel_b}, 32'd2);
        chk("R4", opnd_b, mval);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule